// File: doc/BRIEF.md
# Two-Wire Bus Clock Divider Chain

This block generates the timing for a two-wire serial controller acting as bus master. From the reference clock it produces two outputs. The first is a one-cycle sampling enable. The second is the serial bus clock level, with a one-cycle marker on each of its transitions. Three stages in cascade set the rates. The first stage divides the reference clock by an offset half-period value, which gives an internal tick. The second stage is a power-of-two prescaler on that tick, and its output is the sampling rate. The third stage divides the sampling rate by a multiplier times a fixed factor. The fixed factor is 10 for bus rates up to 400 kHz and 15 for the faster range.

Software programs three registers through a one-cycle write port: a half-period value, a clock-control byte that holds the prescaler exponent and the multiplier, and a mode byte. The mode byte holds the speed bit and a reference-source select bit. The reference-source bit is passed to the clock selection upstream. A write to any of the three registers restarts the whole chain, so the first period after the write already uses the new ratio. With a 100 MHz reference and reset values, the block produces a sample every 7 cycles and a bus period of 70 cycles.

`rst_n` is asserted asynchronously. It is expected to deassert in step with `clk`, because a synchronizer upstream handles the release.

Top module: `twbus_clkdiv`

## Requirements
- R1: After reset, `samp_en` and `scl_edge` are 0, `scl_out` is 1 and `ref_sel` is 0. All registers read as zero, so the chain runs with half-period 5 (clamped), exponent 0, multiplier 0 and factor 10: a sample every 7 cycles and a bus period of 10 samples.
- R2: With half-period value T at `cfg_addr` 0, the tick period is T+2 reference cycles. The first `samp_en` pulse appears (T+2)·2^N cycles after the restart edge.
- R3: The prescaler exponent N is bits 2:0 of the clock-control byte at `cfg_addr` 1, and the sample period is 2^N ticks. Bit 7 of that byte is ignored.
- R4: The multiplier M is bits 6:3 of the clock-control byte. The bus clock period L is (M+1)·D sample periods, with D = 10 when mode bit 0 (`cfg_addr` 2) is clear.
- R5: When mode bit 0 is set, D = 15.
- R6: After a restart, `scl_out` starts high. It falls on the ceil(L/2)-th sample pulse and rises again on the L-th, so the high phase is ceil(L/2) samples and the low phase is floor(L/2) samples.
- R7: `samp_en` is high for exactly one cycle per sample. `scl_edge` is a one-cycle pulse, high in the same cycle as `samp_en` and in the cycle where `scl_out` first shows its new level.
- R8: Half-period values 0 to 4 behave exactly as 5.
- R9: A write to `cfg_addr` 0, 1 or 2 clears all three stages at that clock edge. In the next cycle `scl_out` is 1 and `samp_en` is 0, and the timing of R2 and R6 restarts from that edge.
- R10: A write to `cfg_addr` 3 changes no register, does not restart the chain and does not change `ref_sel`.
- R11: While `en` is 0, all stages are held cleared: `scl_out` is 1 and no `samp_en` or `scl_edge` pulse occurs. When `en` returns to 1, the chain starts from zero, as after a restart.
- R12: `ref_sel` follows mode bit 4. The other mode bits besides bits 0 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Divider enable; 0 holds the chain idle |
| cfg_we | input | 1 | One-cycle register write strobe |
| cfg_addr | input | 2 | Register select: 0 half-period, 1 clock control, 2 mode, 3 unused |
| cfg_wdata | input | 8 | Write data |
| samp_en | output | 1 | One-cycle pulse at the sampling rate |
| scl_out | output | 1 | Bus clock level |
| scl_edge | output | 1 | One-cycle pulse on each bus clock transition |
| ref_sel | output | 1 | Reference-source select (mode bit 4) |

## Verification
The properties assume that `cfg_addr`, `cfg_we` and `en` are always at known levels. They also assume that the shortest sample period is 7 cycles, which follows from the clamp on the half-period and which the single-cycle check on `samp_en` relies on. The stimulus drives every input from time zero and changes inputs only on falling edges. Each write lasts one cycle. `en` is toggled only between complete measurement windows, so every window starts from a known restart edge.

// File: rtl/twclk_pkg.sv
package twclk_pkg;

  localparam int HALF_W  = 8;
  localparam int NSEL_W  = 3;
  localparam int MSEL_W  = 4;
  localparam int CFG_W   = 8;
  localparam int HS_BIT  = 0;
  localparam int REF_BIT = 4;
  localparam int PRE_W   = (1 << NSEL_W) - 1;

  typedef enum logic [1:0] {
    CFG_HALF = 2'd0,
    CFG_CTRL = 2'd1,
    CFG_MODE = 2'd2,
    CFG_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [HALF_W-1:0] half;
    logic [NSEL_W-1:0] nsel;
    logic [MSEL_W-1:0] msel;
    logic              hs;
    logic              ref_src;
  } div_cfg_t;

endpackage

// File: rtl/twclk_cfg_regs.sv
module twclk_cfg_regs
  import twclk_pkg::*;
#(
  parameter int THP_MIN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output div_cfg_t         cfg_o,
  output logic             restart_o
);

  localparam int CTRL_W = NSEL_W + MSEL_W;

  logic [HALF_W-1:0] half_q, half_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              hs_q, hs_d;
  logic              ref_q, ref_d;
  cfg_sel_e          sel;

  assign sel = cfg_sel_e'(cfg_addr);

  always_comb begin
    half_d = half_q;
    ctrl_d = ctrl_q;
    hs_d   = hs_q;
    ref_d  = ref_q;
    if (cfg_we) begin
      case (sel)
        CFG_HALF: half_d = cfg_wdata[HALF_W-1:0];
        CFG_CTRL: ctrl_d = cfg_wdata[CTRL_W-1:0];
        CFG_MODE: begin
          hs_d  = cfg_wdata[HS_BIT];
          ref_d = cfg_wdata[REF_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      ctrl_q <= '0;
      hs_q   <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      ctrl_q <= ctrl_d;
      hs_q   <= hs_d;
      ref_q  <= ref_d;
    end
  end

  assign restart_o = cfg_we && (sel != CFG_NONE);

  always_comb begin
    cfg_o.half    = (half_q < HALF_W'(THP_MIN)) ? HALF_W'(THP_MIN) : half_q;
    cfg_o.nsel    = ctrl_q[NSEL_W-1:0];
    cfg_o.msel    = ctrl_q[CTRL_W-1:NSEL_W];
    cfg_o.hs      = hs_q;
    cfg_o.ref_src = ref_q;
  end

endmodule

// File: rtl/twclk_tick_div.sv
module twclk_tick_div
  import twclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [HALF_W-1:0] half,
  output logic              tick_o
);

  localparam int CNT_W = HALF_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, term;
  logic             at_term;

  assign term    = {1'b0, half} + CNT_W'(1);
  assign at_term = (cnt_q >= term);

  always_comb begin
    if (clr)          cnt_d = '0;
    else if (at_term) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = !clr && at_term;

endmodule

// File: rtl/twclk_prescale.sv
module twclk_prescale
  import twclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick_i,
  input  logic [NSEL_W-1:0] nsel,
  output logic              samp_c_o,
  output logic              samp_q_o
);

  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_lim;
  logic             samp_d;

  assign one_sh = {{PRE_W{1'b0}}, 1'b1} << nsel;
  assign lim    = PRE_W'(one_sh - 1'b1);
  assign at_lim = (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (clr)          pre_d = '0;
    else if (tick_i)  pre_d = at_lim ? '0 : pre_q + PRE_W'(1);
  end

  assign samp_d = !clr && tick_i && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      samp_q_o <= 1'b0;
    end else begin
      pre_q    <= pre_d;
      samp_q_o <= samp_d;
    end
  end

  assign samp_c_o = samp_d;

endmodule

// File: rtl/twclk_final.sv
module twclk_final
  import twclk_pkg::*;
#(
  parameter int D_LS = 10,
  parameter int D_HS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              samp_i,
  input  logic [MSEL_W-1:0] msel,
  input  logic              hs,
  output logic              bus_o,
  output logic              edge_o
);

  localparam int D_MAX   = (D_HS > D_LS) ? D_HS : D_LS;
  localparam int MAX_LEN = (1 << MSEL_W) * D_MAX;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] mul1, dsel, len, half_len, last, mid;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             bus_q, bus_d;
  logic             edge_q, edge_d;

  assign mul1     = LEN_W'(msel) + LEN_W'(1);
  assign dsel     = hs ? LEN_W'(D_HS) : LEN_W'(D_LS);
  assign len      = mul1 * dsel;
  assign half_len = (len + LEN_W'(1)) >> 1;
  assign last     = len - LEN_W'(1);
  assign mid      = half_len - LEN_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    bus_d = bus_q;
    if (clr) begin
      cnt_d = '0;
      bus_d = 1'b1;
    end else if (samp_i) begin
      if (cnt_q >= last) begin
        cnt_d = '0;
        bus_d = 1'b1;
      end else begin
        cnt_d = cnt_q + LEN_W'(1);
        if (cnt_q == mid) bus_d = 1'b0;
      end
    end
    edge_d = !clr && (bus_d != bus_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bus_q  <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bus_q  <= bus_d;
      edge_q <= edge_d;
    end
  end

  assign bus_o  = bus_q;
  assign edge_o = edge_q;

endmodule

// File: rtl/twbus_clkdiv.sv
module twbus_clkdiv
  import twclk_pkg::*;
#(
  parameter int THP_MIN = 5,
  parameter int D_LS    = 10,
  parameter int D_HS    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             samp_en,
  output logic             scl_out,
  output logic             scl_edge,
  output logic             ref_sel
);

  div_cfg_t cfg;
  logic     restart;
  logic     clr;
  logic     tick;
  logic     samp_c;

  twclk_cfg_regs #(.THP_MIN(THP_MIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  assign clr = !en || restart;

  twclk_tick_div u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .half   (cfg.half),
    .tick_o (tick)
  );

  twclk_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .tick_i   (tick),
    .nsel     (cfg.nsel),
    .samp_c_o (samp_c),
    .samp_q_o (samp_en)
  );

  twclk_final #(.D_LS(D_LS), .D_HS(D_HS)) u_fin (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .samp_i (samp_c),
    .msel   (cfg.msel),
    .hs     (cfg.hs),
    .bus_o  (scl_out),
    .edge_o (scl_edge)
  );

  assign ref_sel = cfg.ref_src;

endmodule

// File: rtl/twbus_clkdiv_chk.sv
module twbus_clkdiv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic       samp_en,
  input logic       scl_out,
  input logic       scl_edge
);

  a_r7_samp_single: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |=> !samp_en);

  a_r7_edge_with_samp: assert property (@(posedge clk) disable iff (!rst_n)
    scl_edge |-> samp_en);

  a_r6_edge_flips_level: assert property (@(posedge clk) disable iff (!rst_n)
    scl_edge |-> (scl_out != $past(scl_out)));

  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_out && !samp_en && !scl_edge));

  a_r9_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != 2'd3) |=> (scl_out && !samp_en));

endmodule

bind twbus_clkdiv twbus_clkdiv_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .samp_en  (samp_en),
  .scl_out  (scl_out),
  .scl_edge (scl_edge)
);

// File: tb/twbus_clkdiv_tb.sv
module twbus_clkdiv_tb;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       samp_en;
  logic       scl_out;
  logic       scl_edge;
  logic       ref_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  twbus_clkdiv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .samp_en   (samp_en),
    .scl_out   (scl_out),
    .scl_edge  (scl_edge),
    .ref_sel   (ref_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  // caller sits at a falling edge; returns at the falling edge after the write edge
  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic setup(input logic [7:0] half, input logic [7:0] ctrl, input logic [7:0] mode);
    write_reg(2'd2, mode);
    write_reg(2'd0, half);
    write_reg(2'd1, ctrl);
  endtask

  // measures one full bus period starting from the last restart edge
  task automatic check_chain(input int s, input int l, input string tag);
    int  h     = (l + 1) / 2;
    int  first = -1;
    int  fall  = -1;
    int  rise  = -1;
    int  ns    = 0;
    int  ne    = 0;
    bit  prev  = 0;
    bit  twin  = 0;
    for (int n = 1; n <= l * s + 1; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (samp_en) begin
        if (first < 0) first = n;
        if (n <= l * s) ns++;
        if (prev) twin = 1;
      end
      prev = samp_en;
      if (scl_edge && n <= l * s) ne++;
      if (!scl_out && fall < 0) fall = n;
      if (scl_out && fall >= 0 && rise < 0) rise = n;
    end
    check(first == s, $sformatf("%s R2 first sample", tag), first, s);
    check(fall == h * s, $sformatf("%s R6 bus clock fall", tag), fall, h * s);
    check(rise == l * s, $sformatf("%s R4 bus clock period", tag), rise, l * s);
    check(ns == l, $sformatf("%s R4 samples per period", tag), ns, l);
    check(ne == 2 && !twin, $sformatf("%s R7 edge pulses", tag), ne, 2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(samp_en == 1'b0, "R1 reset samp_en", int'(samp_en), 0);
    check(scl_out == 1'b1, "R1 reset scl_out", int'(scl_out), 1);
    check(scl_edge == 1'b0, "R1 reset scl_edge", int'(scl_edge), 0);
    check(ref_sel == 1'b0, "R1 reset ref_sel", int'(ref_sel), 0);
    rst_n = 1'b1;
    check_chain(7, 10, "R1 defaults");
  endtask

  task automatic t_lowspeed_basic();
    setup(8'd5, 8'h00, 8'h00);
    check_chain(7, 10, "R2 half 5");
  endtask

  task automatic t_prescale_mult();
    // N=2 (bits 2:0), M=1 (bits 6:3): sample 10*4, period 20 samples
    setup(8'd8, 8'h0A, 8'h00);
    check_chain(40, 20, "R3 N2 M1");
  endtask

  task automatic t_highspeed_odd();
    // N=1, M=0, D=15: sample 14, period 15 samples
    setup(8'd5, 8'h01, 8'h01);
    check_chain(14, 15, "R5 hs M0");
  endtask

  task automatic t_highspeed_m2();
    setup(8'd6, 8'h10, 8'h01);
    check_chain(8, 45, "R5 hs M2");
  endtask

  task automatic t_clamp();
    setup(8'd3, 8'h00, 8'h00);
    check_chain(7, 10, "R8 half 3");
    write_reg(2'd0, 8'd0);
    check_chain(7, 10, "R8 half 0");
  endtask

  task automatic t_ctrl_bit7();
    setup(8'd5, 8'h81, 8'h00);
    check_chain(14, 10, "R3 bit7 ignored");
  endtask

  task automatic t_refsel();
    setup(8'd5, 8'h00, 8'h10);
    check(ref_sel == 1'b1, "R12 ref bit set", int'(ref_sel), 1);
    check_chain(7, 10, "R12 ref only");
    write_reg(2'd2, 8'hEE);
    check(ref_sel == 1'b0, "R12 other bits", int'(ref_sel), 0);
    check_chain(7, 10, "R12 other bits");
    write_reg(2'd2, 8'h11);
    check(ref_sel == 1'b1, "R12 ref with hs", int'(ref_sel), 1);
    check_chain(7, 15, "R12 ref with hs");
  endtask

  task automatic t_ignored_addr();
    int first = -1;
    int ns    = 0;
    int fall  = -1;
    setup(8'd5, 8'h00, 8'h00);
    for (int n = 1; n <= 36; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (samp_en) begin
        if (first < 0) first = n;
        if (n <= 35) ns++;
      end
      if (!scl_out && fall < 0) fall = n;
      if (n == 3) begin
        cfg_we    = 1'b1;
        cfg_addr  = 2'd3;
        cfg_wdata = 8'hFF;
      end else begin
        cfg_we = 1'b0;
      end
    end
    check(first == 7, "R10 first sample", first, 7);
    check(ns == 5, "R10 samples unchanged", ns, 5);
    check(fall == 35, "R10 no restart", fall, 35);
    check(ref_sel == 1'b0, "R10 ref_sel kept", int'(ref_sel), 0);
  endtask

  task automatic t_restart_midrun();
    setup(8'd5, 8'h00, 8'h00);
    repeat (40) @(negedge clk);
    check(scl_out == 1'b0, "R6 low phase", int'(scl_out), 0);
    write_reg(2'd0, 8'd6);
    check(scl_out == 1'b1 && samp_en == 1'b0, "R9 restart state", int'(scl_out), 1);
    check_chain(8, 10, "R9 restart");
  endtask

  task automatic t_enable_gate();
    int bad = 0;
    setup(8'd5, 8'h00, 8'h00);
    repeat (20) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!scl_out || samp_en || scl_edge) bad++;
    end
    check(bad == 0, "R11 idle while disabled", bad, 0);
    en = 1'b1;
    check_chain(7, 10, "R11 re-enable");
  endtask

  initial begin
    rst_n     = 1'b0;
    en        = 1'b1;
    cfg_we    = 1'b0;
    cfg_addr  = 2'd0;
    cfg_wdata = 8'd0;
    @(negedge clk);
    t_reset();
    t_lowspeed_basic();
    t_prescale_mult();
    t_highspeed_odd();
    t_highspeed_m2();
    t_clamp();
    t_ctrl_bit7();
    t_refsel();
    t_ignored_addr();
    t_restart_midrun();
    t_enable_gate();
    report();
  end

endmodule